// File: doc/BRIEF.md
# NAND Flash Host Bridge with Ready Interrupt

The bridge sits between a 16-bit processor register bus and the 8-bit pin interface of a NAND flash device. Software writes a command byte into a control register to choose what kind of flash cycle follows: plain data, a command byte with CLE raised, an address byte with ALE raised, or standby with the chip deselected. The same register also switches the card supply on or off. Every access to the data register becomes one or two strobed byte cycles on the flash pins. A 16-bit access moves two bytes, with the low byte first. The bus access is held until those cycles finish.

The ready/busy pin is synchronised and shown as a busy flag. When the pin rises, which means the flash has finished an operation, a sticky status bit is set. If the matching mask bit is set, that status bit drives the interrupt output. Software clears status bits by writing ones to them.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are 1, nf_cle, nf_ale, nf_pwr_en and irq are 0, and the control register (offset 4) reads 0x00.
- R2: Control register at offset 4 is readable. Bit 4 set drives nf_ce_n low, bit 0 drives nf_cle and bit 1 drives nf_ale. So 0x94 gives data cycles, 0x95 command cycles, 0x96 address cycles and 0x00 standby with nf_ce_n high.
- R3: A control write whose bits 7:4 are 0 and whose bit 3 is 1 loads nf_pwr_en from bit 2 (0x0C on, 0x08 off). Any other control write leaves nf_pwr_en unchanged.
- R4: A 16-bit write to the data register (offset 0, bus_size16=1) makes two nf_we_n pulses. The first carries bits 7:0 and the second bits 15:8. Each pulse is low for exactly two clocks after one setup clock, and nf_we_n and nf_re_n are never low together.
- R5: A 16-bit read of the data register makes two nf_re_n pulses, each low for two clocks. The first byte read lands in bus_rdata[7:0] and the second in bus_rdata[15:8]. An 8-bit read makes one pulse and returns the byte zero-extended.
- R6: An 8-bit data-register access (bus_size16=0) makes exactly one flash cycle. This is how single command and address bytes are sent.
- R7: Status register (offset 5) bit 7 reads 1 while nf_rb is low (busy), after a two-clock synchroniser. All other bits read 0.
- R8: A rising edge of the synchronised nf_rb sets interrupt status bit 0 (offset 6, four bits). Writing 1 to a status bit clears it, so 0x0F clears all. A set and a clear in the same cycle leave the bit set.
- R9: The mask register (offset 7) is readable, and irq is the OR of the status bits ANDed with mask bits 3:0. So 0x81 enables the ready interrupt and 0x00 keeps irq low.
- R10: bus_ready is a one-clock pulse. It comes one clock after a register access is accepted, five clocks after an 8-bit data access and nine clocks after a 16-bit data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_size16 | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Byte driven to the flash |
| nf_dq_oe | output | 1 | Output enable for nf_dq_o |
| nf_dq_i | input | 8 | Byte returned by the flash |
| nf_rb | input | 1 | Ready/busy pin, 1 = ready |
| nf_pwr_en | output | 1 | Card supply enable |
| irq | output | 1 | Interrupt request |

## Verification
The set of the ready status bit by a rising nf_rb edge can land in the same clock as a software write of 0x0F that clears the status register. The bench counts the synchroniser stages and raises nf_rb exactly two clocks before the clear write is accepted, so that both updates reach the register at the same edge. The status bit must then read back as 1, because a ready event that arrives together with a clear must not be lost. A second clear that has no event beside it must then read back 0.

// File: rtl/nhb_pkg.sv
package nhb_pkg;

  localparam int unsigned IRQ_N = 4;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_CTRL = 3'd4;
  localparam logic [2:0] OFF_STAT = 3'd5;
  localparam logic [2:0] OFF_ISR  = 3'd6;
  localparam logic [2:0] OFF_IMR  = 3'd7;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_XFER = 2'd1,
    HS_ACK  = 2'd2
  } host_state_e;

  typedef struct packed {
    logic ce;
    logic cle;
    logic ale;
  } pin_ctl_t;

  // Strobe lines chosen by a control-register byte
  function automatic pin_ctl_t decode_ctrl(input logic [7:0] v);
    pin_ctl_t p;
    p.ce  = v[4];
    p.cle = v[0];
    p.ale = v[1];
    return p;
  endfunction

  // Supply commands have an empty upper nibble and bit 3 set
  function automatic logic is_supply_cmd(input logic [7:0] v);
    return (v[7:4] == 4'h0) && v[3];
  endfunction

  // Sticky status update: clear by ones, new events win
  function automatic logic [IRQ_N-1:0] status_next(input logic [IRQ_N-1:0] cur,
                                                   input logic [IRQ_N-1:0] set,
                                                   input logic [IRQ_N-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/nhb_ctrl_reg.sv
module nhb_ctrl_reg
  import nhb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o,
  output pin_ctl_t   pins_o,
  output logic       pwr_o
);

  logic [7:0] ctrl_q;
  logic       pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      pwr_q  <= 1'b0;
    end else if (wr_i) begin
      ctrl_q <= wdata_i;
      if (is_supply_cmd(wdata_i)) pwr_q <= wdata_i[2];
    end
  end

  assign ctrl_o = ctrl_q;
  assign pins_o = decode_ctrl(ctrl_q);
  assign pwr_o  = pwr_q;

endmodule

// File: rtl/nhb_strobe_gen.sv
module nhb_strobe_gen #(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned LOW_CYC   = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] nf_dq_i,
  output logic       done_o,
  output logic       we_low_o,
  output logic       re_low_o,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       cap_o,
  output logic [7:0] cap_byte_o
);

  localparam int unsigned TOTAL = SETUP_CYC + LOW_CYC + HOLD_CYC;
  localparam int unsigned CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [CNT_W-1:0] LOW_FIRST = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(SETUP_CYC + LOW_CYC - 1);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(TOTAL - 1);

  logic             busy_q;
  logic             rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       byte_q;
  logic             low_phase;
  logic             last_phase;

  assign low_phase  = busy_q && (cnt_q >= LOW_FIRST) && (cnt_q <= LOW_LAST);
  assign last_phase = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      byte_q <= 8'h00;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      cnt_q  <= '0;
      byte_q <= byte_i;
    end else if (busy_q) begin
      if (last_phase) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign done_o     = last_phase;
  assign we_low_o   = low_phase && !rd_q;
  assign re_low_o   = low_phase && rd_q;
  assign dq_o       = byte_q;
  assign dq_oe_o    = busy_q && !rd_q;
  assign cap_o      = busy_q && rd_q && (cnt_q == LOW_LAST);
  assign cap_byte_o = nf_dq_i;

endmodule

// File: rtl/nhb_ready_irq.sv
module nhb_ready_irq
  import nhb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nf_rb_i,
  input  logic             isr_wr_i,
  input  logic             imr_wr_i,
  input  logic [7:0]       wdata_i,
  output logic             busy_o,
  output logic             rise_o,
  output logic [IRQ_N-1:0] isr_o,
  output logic [7:0]       imr_o,
  output logic             irq_o
);

  logic [SYNC_STAGES:0] sh_q;
  logic [IRQ_N-1:0]     isr_q;
  logic [7:0]           imr_q;
  logic [IRQ_N-1:0]     set_vec;
  logic [IRQ_N-1:0]     clr_vec;
  logic                 rdy_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], nf_rb_i};
  end

  assign rdy_now = sh_q[SYNC_STAGES-1];
  assign rise_o  = rdy_now && !sh_q[SYNC_STAGES];
  assign busy_o  = !rdy_now;

  assign set_vec = {{(IRQ_N-1){1'b0}}, rise_o};
  assign clr_vec = isr_wr_i ? wdata_i[IRQ_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      imr_q <= 8'h00;
    end else begin
      isr_q <= status_next(isr_q, set_vec, clr_vec);
      if (imr_wr_i) imr_q <= wdata_i;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;
  assign irq_o = |(isr_q & imr_q[IRQ_N-1:0]);

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nhb_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned LOW_CYC     = 2,
  parameter int unsigned HOLD_CYC    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic        bus_size16,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_ready,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_i,
  input  logic        nf_rb,
  output logic        nf_pwr_en,
  output logic        irq
);

  host_state_e      state_q;
  logic             two_q;
  logic             idx_q;
  logic             rd_xfer_q;
  logic [7:0]       hi_byte_q;
  logic [15:0]      rdata_q;

  logic             accept_w;
  logic             is_data_w;
  logic             last_byte_w;
  logic             eng_start_w;
  logic             eng_rd_w;
  logic [7:0]       eng_byte_w;
  logic             eng_done_w;
  logic             we_low_w;
  logic             re_low_w;
  logic             cap_w;
  logic [7:0]       cap_byte_w;
  logic             ctrl_wr_w;
  logic             isr_wr_w;
  logic             imr_wr_w;
  logic [7:0]       ctrl_w;
  pin_ctl_t         pins_w;
  logic             busy_w;
  logic             rdy_rise_w;
  logic [IRQ_N-1:0] isr_w;
  logic [7:0]       imr_w;
  logic [7:0]       reg_rd_w;

  assign accept_w    = (state_q == HS_IDLE) && bus_req;
  assign is_data_w   = (bus_addr == OFF_DATA);
  assign last_byte_w = !two_q || idx_q;
  assign eng_start_w = (accept_w && is_data_w) ||
                       ((state_q == HS_XFER) && eng_done_w && !last_byte_w);
  assign eng_rd_w    = (state_q == HS_IDLE) ? !bus_we : rd_xfer_q;
  assign eng_byte_w  = (state_q == HS_IDLE) ? bus_wdata[7:0] : hi_byte_q;

  assign ctrl_wr_w = accept_w && bus_we && (bus_addr == OFF_CTRL);
  assign isr_wr_w  = accept_w && bus_we && (bus_addr == OFF_ISR);
  assign imr_wr_w  = accept_w && bus_we && (bus_addr == OFF_IMR);

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL: reg_rd_w = ctrl_w;
      OFF_STAT: reg_rd_w = {busy_w, 7'b0};
      OFF_ISR:  reg_rd_w = {{(8-IRQ_N){1'b0}}, isr_w};
      OFF_IMR:  reg_rd_w = imr_w;
      default:  reg_rd_w = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      two_q     <= 1'b0;
      idx_q     <= 1'b0;
      rd_xfer_q <= 1'b0;
      hi_byte_q <= 8'h00;
      rdata_q   <= 16'h0000;
    end else begin
      unique case (state_q)
        HS_IDLE: if (accept_w) begin
          if (is_data_w) begin
            state_q   <= HS_XFER;
            two_q     <= bus_size16;
            idx_q     <= 1'b0;
            rd_xfer_q <= !bus_we;
            hi_byte_q <= bus_wdata[15:8];
            rdata_q   <= 16'h0000;
          end else begin
            state_q <= HS_ACK;
            if (!bus_we) rdata_q <= {8'h00, reg_rd_w};
          end
        end
        HS_XFER: begin
          if (cap_w) begin
            if (idx_q) rdata_q[15:8] <= cap_byte_w;
            else       rdata_q[7:0]  <= cap_byte_w;
          end
          if (eng_done_w) begin
            if (last_byte_w) state_q <= HS_ACK;
            else             idx_q   <= 1'b1;
          end
        end
        HS_ACK:  state_q <= HS_IDLE;
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  nhb_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctrl_wr_w),
    .wdata_i (bus_wdata[7:0]),
    .ctrl_o  (ctrl_w),
    .pins_o  (pins_w),
    .pwr_o   (nf_pwr_en)
  );

  nhb_strobe_gen #(
    .SETUP_CYC (SETUP_CYC),
    .LOW_CYC   (LOW_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (eng_start_w),
    .rd_i       (eng_rd_w),
    .byte_i     (eng_byte_w),
    .nf_dq_i    (nf_dq_i),
    .done_o     (eng_done_w),
    .we_low_o   (we_low_w),
    .re_low_o   (re_low_w),
    .dq_o       (nf_dq_o),
    .dq_oe_o    (nf_dq_oe),
    .cap_o      (cap_w),
    .cap_byte_o (cap_byte_w)
  );

  nhb_ready_irq #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rdy (
    .clk      (clk),
    .rst_n    (rst_n),
    .nf_rb_i  (nf_rb),
    .isr_wr_i (isr_wr_w),
    .imr_wr_i (imr_wr_w),
    .wdata_i  (bus_wdata[7:0]),
    .busy_o   (busy_w),
    .rise_o   (rdy_rise_w),
    .isr_o    (isr_w),
    .imr_o    (imr_w),
    .irq_o    (irq)
  );

  assign bus_ready = (state_q == HS_ACK);
  assign bus_rdata = rdata_q;
  assign nf_ce_n   = !pins_w.ce;
  assign nf_cle    = pins_w.cle;
  assign nf_ale    = pins_w.ale;
  assign nf_we_n   = !we_low_w;
  assign nf_re_n   = !re_low_w;

endmodule

// File: rtl/nhb_checker.sv
module nhb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic [7:0] nf_dq_o,
  input logic       bus_ready,
  input logic       rdy_rise,
  input logic [3:0] isr,
  input logic [7:0] imr,
  input logic       irq
);

  // R4: strobes never overlap
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  // R4: write strobe low for at least two clocks
  a_r4_we_low_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_we_n) |=> !nf_we_n);

  // R5: read strobe low for at least two clocks
  a_r5_re_low_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |=> !nf_re_n);

  // R4: byte held while the write strobe stays low
  a_r4_dq_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_dq_o));

  // R2: latch enables do not move under a write strobe
  a_r2_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_cle) && $stable(nf_ale)));

  // R8: a ready edge leaves status bit 0 set
  a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_rise |=> isr[0]);

  // R9: an empty mask keeps the interrupt quiet
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr[3:0] == 4'h0) |-> !irq);

  // R10: completion is a single-clock pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

endmodule

bind nand_host_bridge nhb_checker u_nhb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nf_we_n   (nf_we_n),
  .nf_re_n   (nf_re_n),
  .nf_cle    (nf_cle),
  .nf_ale    (nf_ale),
  .nf_dq_o   (nf_dq_o),
  .bus_ready (bus_ready),
  .rdy_rise  (rdy_rise_w),
  .isr       (isr_w),
  .imr       (imr_w),
  .irq       (irq)
);

// File: tb/nand_host_bridge_tb_top.sv
module nand_host_bridge_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_size16 = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_ready;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_pwr_en, irq;
  logic [7:0]  nf_dq_o;
  logic [7:0]  nf_dq_i = 8'h00;
  logic        nf_rb = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  int we_pulses = 0;
  int re_pulses = 0;
  int we_low_cnt = 0;
  int re_low_cnt = 0;
  bit finished = 0;

  logic [9:0] exp_wr_q[$];   // {cle, ale, byte}
  logic [7:0] flash_rd_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_host_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size16(bus_size16), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb),
    .nf_pwr_en(nf_pwr_en), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // strobe low-time counters, sampled away from the active edge
  always @(negedge clk) begin
    we_low_cnt <= nf_we_n ? 0 : we_low_cnt + 1;
    re_low_cnt <= nf_re_n ? 0 : re_low_cnt + 1;
  end

  // scoreboard monitor: every write strobe pops one expected cycle
  always @(posedge nf_we_n) begin
    if (rst_n) begin
      we_pulses++;
      chk(we_low_cnt == 2, "R4 we low width", we_low_cnt, 2);
      if (exp_wr_q.size() == 0) begin
        chk(1'b0, "R6 unexpected flash write", {22'd0, nf_cle, nf_ale, nf_dq_o}, 0);
      end else begin
        logic [9:0] e;
        e = exp_wr_q.pop_front();
        chk({nf_cle, nf_ale, nf_dq_o} == e, "R4 flash write cycle",
            {22'd0, nf_cle, nf_ale, nf_dq_o}, {22'd0, e});
      end
    end
  end

  always @(posedge nf_re_n) begin
    if (rst_n) begin
      re_pulses++;
      chk(re_low_cnt == 2, "R5 re low width", re_low_cnt, 2);
    end
  end

  // flash model: present next byte when read strobe falls
  always @(negedge nf_re_n) begin
    if (flash_rd_q.size() > 0) nf_dq_i = flash_rd_q.pop_front();
    else                       nf_dq_i = 8'hEE;
  end

  task automatic bus_acc(input logic we, input logic [2:0] a, input logic sz16,
                         input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size16 = sz16; bus_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ready && lat < 50);
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] v);
    logic [15:0] rd; int lat;
    bus_acc(1'b1, a, 1'b0, {8'h00, v}, rd, lat);
    chk(lat == 1, "R10 register write latency", lat, 1);
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] v);
    logic [15:0] rd; int lat;
    bus_acc(1'b0, a, 1'b0, 16'h0, rd, lat);
    v = rd[7:0];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] rd;
    int lat;
    int wp;
    int rp;

    repeat (3) @(negedge clk);
    chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle in reset",
        {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!nf_cle && !nf_ale && !nf_pwr_en && !irq, "R1 outputs low after reset",
        {nf_cle, nf_ale, nf_pwr_en, irq}, 0);
    reg_rd(3'd4, v);
    chk(v == 8'h00, "R1 control reads zero", v, 8'h00);

    // R3 supply control
    reg_wr(3'd4, 8'h0C);
    chk(nf_pwr_en == 1'b1, "R3 supply on", nf_pwr_en, 1);
    chk(nf_ce_n == 1'b1, "R2 supply byte leaves chip deselected", nf_ce_n, 1);
    reg_wr(3'd4, 8'h08);
    chk(nf_pwr_en == 1'b0, "R3 supply off", nf_pwr_en, 0);
    reg_wr(3'd4, 8'h0C);
    reg_wr(3'd4, 8'h95);
    chk(nf_pwr_en == 1'b1, "R3 non-supply write keeps supply", nf_pwr_en, 1);

    // R2 command mode
    chk({nf_ce_n, nf_cle, nf_ale} == 3'b010, "R2 command mode pins",
        {nf_ce_n, nf_cle, nf_ale}, 3'b010);
    reg_rd(3'd4, v);
    chk(v == 8'h95, "R2 control readback", v, 8'h95);

    // R6 single command byte
    wp = we_pulses;
    exp_wr_q.push_back({2'b10, 8'hFF});
    bus_acc(1'b1, 3'd0, 1'b0, 16'hAAFF, rd, lat);
    chk(lat == 5, "R10 8-bit data latency", lat, 5);
    chk(we_pulses - wp == 1, "R6 one cycle for 8-bit write", we_pulses - wp, 1);
    chk(exp_wr_q.size() == 0, "R6 command byte consumed", exp_wr_q.size(), 0);

    // R4 address mode, 16-bit write, low byte first
    reg_wr(3'd4, 8'h96);
    chk({nf_cle, nf_ale} == 2'b01, "R2 address mode pins", {nf_cle, nf_ale}, 2'b01);
    wp = we_pulses;
    exp_wr_q.push_back({2'b01, 8'h34});
    exp_wr_q.push_back({2'b01, 8'h12});
    bus_acc(1'b1, 3'd0, 1'b1, 16'h1234, rd, lat);
    chk(lat == 9, "R10 16-bit data latency", lat, 9);
    chk(we_pulses - wp == 2, "R4 two cycles for 16-bit write", we_pulses - wp, 2);
    chk(exp_wr_q.size() == 0, "R4 address bytes consumed", exp_wr_q.size(), 0);

    // R5 data mode reads
    reg_wr(3'd4, 8'h94);
    chk({nf_ce_n, nf_cle, nf_ale} == 3'b000, "R2 data mode pins",
        {nf_ce_n, nf_cle, nf_ale}, 3'b000);
    rp = re_pulses;
    flash_rd_q.push_back(8'hA5);
    flash_rd_q.push_back(8'h3C);
    bus_acc(1'b0, 3'd0, 1'b1, 16'h0, rd, lat);
    chk(rd == 16'h3CA5, "R5 16-bit read byte order", rd, 16'h3CA5);
    chk(re_pulses - rp == 2, "R5 two read cycles", re_pulses - rp, 2);
    rp = re_pulses;
    flash_rd_q.push_back(8'h77);
    bus_acc(1'b0, 3'd0, 1'b0, 16'h0, rd, lat);
    chk(rd == 16'h0077, "R5 8-bit read zero-extended", rd, 16'h0077);
    chk(re_pulses - rp == 1, "R6 one cycle for 8-bit read", re_pulses - rp, 1);

    // R2 standby
    reg_wr(3'd4, 8'h00);
    chk(nf_ce_n == 1'b1, "R2 standby deselects", nf_ce_n, 1);

    // R7 busy flag
    @(negedge clk); nf_rb = 1'b0;
    repeat (3) @(negedge clk);
    reg_rd(3'd5, v);
    chk(v == 8'h80, "R7 status busy", v, 8'h80);
    chk(irq == 1'b0, "R9 no irq while busy", irq, 0);

    // R8/R9 ready edge with interrupt enabled
    reg_wr(3'd7, 8'h81);
    reg_rd(3'd7, v);
    chk(v == 8'h81, "R9 mask readback", v, 8'h81);
    @(negedge clk); nf_rb = 1'b1;
    repeat (4) @(negedge clk);
    reg_rd(3'd5, v);
    chk(v == 8'h00, "R7 status ready", v, 8'h00);
    reg_rd(3'd6, v);
    chk(v == 8'h01, "R8 ready edge sets status", v, 8'h01);
    chk(irq == 1'b1, "R9 irq raised", irq, 1);
    reg_wr(3'd6, 8'h0F);
    reg_rd(3'd6, v);
    chk(v == 8'h00, "R8 clear all", v, 8'h00);
    chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);

    // R9 masked event
    reg_wr(3'd7, 8'h00);
    @(negedge clk); nf_rb = 1'b0;
    repeat (4) @(negedge clk);
    nf_rb = 1'b1;
    repeat (4) @(negedge clk);
    reg_rd(3'd6, v);
    chk(v == 8'h01, "R8 event latched while masked", v, 8'h01);
    chk(irq == 1'b0, "R9 masked irq stays low", irq, 0);
    reg_wr(3'd6, 8'h0F);

    // R8 set and clear in the same clock: set wins
    @(negedge clk); nf_rb = 1'b0;
    repeat (4) @(negedge clk);
    nf_rb = 1'b1;
    @(negedge clk);
    bus_acc(1'b1, 3'd6, 1'b0, 16'h000F, rd, lat);
    reg_rd(3'd6, v);
    chk(v == 8'h01, "R8 set wins over clear", v, 8'h01);
    reg_wr(3'd6, 8'h01);
    reg_rd(3'd6, v);
    chk(v == 8'h00, "R8 plain clear", v, 8'h00);

    chk(exp_wr_q.size() == 0, "R6 no stray flash writes", exp_wr_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule